// File: doc/BRIEF.md
# Leading-One Windowed Approximate Multiplier

This block multiplies two unsigned N-bit operands approximately. It does not build a full partial-product array. Each operand is reduced to two narrow K-bit windows. The high window starts at the operand's most significant set bit. The low window starts at the most significant set bit of what remains below the high window. Small K-by-K products of these windows are shifted back into place and added.

A 2-bit mode input selects how many of the four window cross-products are summed. Each extra term moves the result closer to the exact product at the cost of one more small multiplier and one more shifter in the active path. The block suits error-tolerant datapaths such as image filters.

The result is registered once. An operand pair presented with `in_valid` produces its product and `out_valid` on the next clock edge.

Top module: `lead_win_mul`

## Requirements
- R1: The operand width N is a parameter (16 or 32), and the window width K is a parameter with K ≤ N/4. The defaults are N=16 and K=4, and the product is 2N bits wide.
- R2: For an operand whose leading one sits at bit index h, the high window shift is h-(K-1) when h ≥ K-1, and 0 otherwise. The high window is the operand shifted right by that amount and cut to K bits. An operand that fits in K bits is therefore its own window with shift 0, and if both operands fit in K bits the product is exact in every mode.
- R3: The remainder is the operand with every bit at or above the high window shift cleared. The low window and low shift come from the remainder by the same rule as in R2. A zero remainder gives a low window of 0.
- R4: With mode 2'b00, the product is (A high × B high) shifted left by (A high shift + B high shift).
- R5: With mode 2'b01, the product is the mode 2'b00 value plus (A high × B low) shifted left by (A high shift + B low shift).
- R6: With mode 2'b10, the product is the mode 2'b01 value plus (A low × B high) shifted left by (A low shift + B high shift).
- R7: With mode 2'b11, the product is the mode 2'b10 value plus (A low × B low) shifted left by (A low shift + B low shift).
- R8: If either operand is zero, the product is zero in every mode.
- R9: The product never exceeds the exact product, and it never decreases as the mode rises from 2'b00 to 2'b11 for the same operands. Over random operands, the mean error distance at mode 2'b11 is below that at mode 2'b00.
- R10: A cycle with `in_valid` high loads the product and raises `out_valid` at the next rising clock edge. A cycle with `in_valid` low leaves the product unchanged and drives `out_valid` low at the next edge. Reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | N | Unsigned operand A |
| op_b | input | N | Unsigned operand B |
| mode | input | 2 | Number of cross-products summed, minus one |
| out_valid | output | 1 | Product register was loaded at the last edge |
| product | output | 2N | Registered approximate product |

## Verification
Nearly all internal state lives in the window selection, and all of it is combinational ahead of the single output register. A wrong leading-one index, a wrong remainder mask or a wrong shift sum therefore shows at `product` one edge after the operands are presented. It appears as a value that differs from the windowed reference, exceeds the exact product, or falls when the mode rises. The worked operand pair, the zero and small operands, and shaped random operands with spread leading-one positions target each window path separately. A fault in the enable or valid register shows as a changed product, or a raised `out_valid`, in the idle cycle after a transfer.

// File: rtl/lwm_pkg.sv
package lwm_pkg;

  // Mode encoding: number of window cross-products summed, minus one.
  typedef enum logic [1:0] {
    MODE_HH   = 2'b00,
    MODE_HH_L = 2'b01,
    MODE_3T   = 2'b10,
    MODE_4T   = 2'b11
  } lwm_mode_e;

  localparam int unsigned LWM_TERMS = 4;

endpackage

// File: rtl/lwm_lod.sv
module lwm_lod #(
  parameter int unsigned W  = 16,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);

  // Scan upward; the highest set bit wins.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (found) begin
      AST_LOD_TOP: assert ((vec >> idx) == {{(W-1){1'b0}}, 1'b1}); // R2
    end else begin
      AST_LOD_NONE: assert (vec == '0); // R8
    end
  end

endmodule

// File: rtl/lwm_window.sv
module lwm_window #(
  parameter int unsigned N  = 16,
  parameter int unsigned K  = 4,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]  op,
  output logic [K-1:0]  hi_win,
  output logic [SW-1:0] hi_sh,
  output logic [K-1:0]  lo_win,
  output logic [SW-1:0] lo_sh
);

  localparam logic [SW-1:0] KM1 = SW'(K - 1);

  logic [SW-1:0] lead_hi;
  logic          any_hi;
  logic [SW-1:0] lead_lo;
  logic          any_lo;
  logic [N-1:0]  keep_mask;
  logic [N-1:0]  remainder;

  lwm_lod #(.W(N)) u_lod_hi (
    .vec   (op),
    .idx   (lead_hi),
    .found (any_hi)
  );

  // High window placement.
  always_comb begin
    if (any_hi && (lead_hi >= KM1)) begin
      hi_sh = lead_hi - KM1;
    end else begin
      hi_sh = '0;
    end
    hi_win = K'(op >> hi_sh);
  end

  // Bits below the high window form the remainder.
  always_comb begin
    keep_mask = ~({N{1'b1}} << hi_sh);
    remainder = op & keep_mask;
  end

  lwm_lod #(.W(N)) u_lod_lo (
    .vec   (remainder),
    .idx   (lead_lo),
    .found (any_lo)
  );

  // Low window placement.
  always_comb begin
    if (any_lo && (lead_lo >= KM1)) begin
      lo_sh = lead_lo - KM1;
    end else begin
      lo_sh = '0;
    end
    lo_win = K'(remainder >> lo_sh);
  end

  always_comb begin
    AST_WIN_COVER: assert ((({1'b0, N'(hi_win)} << hi_sh) +
                            ({1'b0, N'(lo_win)} << lo_sh)) <= {1'b0, op}); // R9
    if (op[N-1:K-1] != '0) begin
      AST_WIN_NORM: assert (hi_win[K-1]); // R2
    end
    if (lo_win != '0) begin
      AST_WIN_BELOW: assert (lo_sh < hi_sh); // R3
    end
  end

endmodule

// File: rtl/lwm_term.sv
module lwm_term #(
  parameter int unsigned N  = 16,
  parameter int unsigned K  = 4,
  localparam int unsigned SW = $clog2(N),
  localparam int unsigned PW = 2 * N
) (
  input  logic          en,
  input  logic [K-1:0]  x_win,
  input  logic [SW-1:0] x_sh,
  input  logic [K-1:0]  y_win,
  input  logic [SW-1:0] y_sh,
  output logic [PW-1:0] term
);

  logic [2*K-1:0] small_prod;
  logic [SW:0]    shift_sum;

  always_comb begin
    small_prod = (2*K)'(x_win) * (2*K)'(y_win);
    shift_sum  = (SW+1)'(x_sh) + (SW+1)'(y_sh);
  end

  // Barrel shift back into place.
  always_comb begin
    if (en) begin
      term = PW'(small_prod) << shift_sum;
    end else begin
      term = '0;
    end
  end

  always_comb begin
    AST_TERM_ALIGN: assert ((term & ~({PW{1'b1}} << shift_sum)) == '0); // R4
  end

endmodule

// File: rtl/lead_win_mul.sv
module lead_win_mul #(
  parameter int unsigned N  = 16,
  parameter int unsigned K  = 4,
  localparam int unsigned SW = $clog2(N),
  localparam int unsigned PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  input  logic [1:0]    mode,
  output logic          out_valid,
  output logic [PW-1:0] product
);

  import lwm_pkg::*;

  logic [K-1:0]  a_hw, a_lw, b_hw, b_lw;
  logic [SW-1:0] a_hs, a_ls, b_hs, b_ls;
  logic [PW-1:0] terms [LWM_TERMS];
  logic [PW-1:0] sum;
  logic [PW-1:0] prod_q, prod_d;
  logic          vld_q, vld_d;
  logic [PW-1:0] exact_ab;

  lwm_window #(.N(N), .K(K)) u_win_a (
    .op     (op_a),
    .hi_win (a_hw),
    .hi_sh  (a_hs),
    .lo_win (a_lw),
    .lo_sh  (a_ls)
  );

  lwm_window #(.N(N), .K(K)) u_win_b (
    .op     (op_b),
    .hi_win (b_hw),
    .hi_sh  (b_hs),
    .lo_win (b_lw),
    .lo_sh  (b_ls)
  );

  // Term t: A side is high for t<2, B side is high for even t.
  for (genvar t = 0; t < LWM_TERMS; t++) begin : g_term
    logic          t_en;
    logic [K-1:0]  xw, yw;
    logic [SW-1:0] xs, ys;

    if (t == 0) begin : g_always
      assign t_en = 1'b1;
    end else begin : g_gated
      assign t_en = (mode >= 2'(t));
    end

    if (t < 2) begin : g_ahi
      assign xw = a_hw;
      assign xs = a_hs;
    end else begin : g_alo
      assign xw = a_lw;
      assign xs = a_ls;
    end

    if ((t % 2) == 0) begin : g_bhi
      assign yw = b_hw;
      assign ys = b_hs;
    end else begin : g_blo
      assign yw = b_lw;
      assign ys = b_ls;
    end

    lwm_term #(.N(N), .K(K)) u_term (
      .en    (t_en),
      .x_win (xw),
      .x_sh  (xs),
      .y_win (yw),
      .y_sh  (ys),
      .term  (terms[t])
    );
  end

  // Final accumulation; the windows never overshoot, so no carry-out.
  always_comb begin
    sum = '0;
    for (int t = 0; t < LWM_TERMS; t++) begin
      sum = sum + terms[t];
    end
  end

  // Next-state logic with explicit load enable.
  always_comb begin
    vld_d  = in_valid;
    prod_d = prod_q;
    if (in_valid) begin
      prod_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prod_q <= prod_d;
      vld_q  <= vld_d;
    end
  end

  assign product   = prod_q;
  assign out_valid = vld_q;

  // Reference magnitude used only by the checks below.
  assign exact_ab = PW'(op_a) * PW'(op_b);

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(product))); // R10
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((op_a == '0) || (op_b == '0))) |=> (product == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (product <= $past(exact_ab))); // R9

endmodule

// File: tb/tb_lead_win_mul.sv
module tb_lead_win_mul;

  localparam int N = 16;
  localparam int K = 4;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [N-1:0]  op_a, op_b;
  logic [1:0]    mode;
  logic          out_valid;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;

  lead_win_mul #(.N(N), .K(K)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .out_valid (out_valid),
    .product   (product)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Window placement from the requirement text.
  function automatic void place(input longint v, output longint hw, output int hs,
                                output longint lw, output int ls);
    int lead;
    longint rem;
    lead = -1;
    for (int i = 0; i < N; i++) if (v[i]) lead = i;
    hs = (lead >= K - 1) ? lead - (K - 1) : 0;
    hw = (v >> hs) & ((64'd1 << K) - 1);
    rem = v & ((64'd1 << hs) - 1);
    lead = -1;
    for (int i = 0; i < N; i++) if (rem[i]) lead = i;
    ls = (lead >= K - 1) ? lead - (K - 1) : 0;
    lw = (rem >> ls) & ((64'd1 << K) - 1);
  endfunction

  function automatic longint ref_prod(input longint a, input longint b, input int m);
    longint ah, al, bh, bl, s;
    int ahs, als, bhs, bls;
    place(a, ah, ahs, al, als);
    place(b, bh, bhs, bl, bls);
    s = (ah * bh) << (ahs + bhs);
    if (m >= 1) s += (ah * bl) << (ahs + bls);
    if (m >= 2) s += (al * bh) << (als + bhs);
    if (m >= 3) s += (al * bl) << (als + bls);
    return s;
  endfunction

  // One transfer; returns the product seen one edge later.
  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [1:0] m, output longint got);
    @(negedge clk);
    op_a = a; op_b = b; mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = longint'(product);
    check("R10 out_valid after transfer", longint'(out_valid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint got, prev, ex;
    longint med0, med3;
    logic [N-1:0] ra, rb;
    void'($urandom(32'd7351));
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; mode = 2'b00;
    med0 = 0; med3 = 0;
    repeat (3) @(negedge clk);
    check("R10 reset product", longint'(product), 0);
    check("R10 reset out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", longint'(out_valid), 0);

    // Worked example, all four modes (R4..R7).
    apply(16'b0100100011111001, 16'b0011000011101010, 2'b00, got);
    check("R4 mode0 example", got, 64'd226492416);
    apply(16'b0100100011111001, 16'b0011000011101010, 2'b01, got);
    check("R5 mode1 example", got, 64'd230621184);
    apply(16'b0100100011111001, 16'b0011000011101010, 2'b10, got);
    check("R6 mode2 example", got, 64'd233570304);
    apply(16'b0100100011111001, 16'b0011000011101010, 2'b11, got);
    check("R7 mode3 example", got, 64'd233624064);

    // Idle cycle: operands change, product must hold (R10).
    @(negedge clk);
    op_a = 16'hFFFF; op_b = 16'hFFFF; mode = 2'b00;
    @(negedge clk);
    check("R10 hold product", longint'(product), 64'd233624064);
    check("R10 idle out_valid", longint'(out_valid), 0);

    // Zero operands (R8).
    for (int m = 0; m < 4; m++) begin
      apply(16'h0000, 16'hBEEF, 2'(m), got);
      check("R8 zero A", got, 0);
      apply(16'hA5A5, 16'h0000, 2'(m), got);
      check("R8 zero B", got, 0);
    end

    // Operands that fit in K bits multiply exactly (R2).
    apply(16'd15, 16'd15, 2'b00, got);
    check("R2 small exact 15x15", got, 225);
    apply(16'd3, 16'd9, 2'b00, got);
    check("R2 small exact 3x9", got, 27);
    apply(16'd8, 16'd1, 2'b11, got);
    check("R2 small exact 8x1", got, 8);

    // Remainder empty: low window zero (R3).
    apply(16'hF000, 16'h8000, 2'b11, got);
    check("R3 empty remainder", got, 64'h7800_0000);
    apply(16'hFFFF, 16'hFFFF, 2'b00, got);
    check("R1 max operands mode0", got, ref_prod(16'hFFFF, 16'hFFFF, 0));

    // Shaped random operands across all modes.
    for (int v = 0; v < 300; v++) begin
      ra = N'($urandom) >> ($urandom % N);
      rb = N'($urandom) >> ($urandom % N);
      ex = longint'(ra) * longint'(rb);
      prev = 0;
      for (int m = 0; m < 4; m++) begin
        apply(ra, rb, 2'(m), got);
        case (m)
          0: check("R4 random mode0", got, ref_prod(ra, rb, 0));
          1: check("R5 random mode1", got, ref_prod(ra, rb, 1));
          2: check("R6 random mode2", got, ref_prod(ra, rb, 2));
          default: check("R7 random mode3", got, ref_prod(ra, rb, 3));
        endcase
        check("R9 monotone in mode", longint'(got >= prev), 1);
        check("R9 not above exact", longint'(got <= ex), 1);
        prev = got;
        if (m == 0) med0 += ex - got;
        if (m == 3) med3 += ex - got;
      end
    end
    check("R9 mean error drops mode0 to mode3", longint'(med3 < med0), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule